// File: doc/BRIEF.md
# Blanking-Start to Scrambler-Reset Substitutor

This block sits in a multi-lane link symbol stream and watches for blanking-start control symbols. By default it lets a programmable number of blanking-starts through unchanged and replaces the one that follows with a scrambler-reset symbol. The far end uses that symbol to put its descrambler back in step. A programmed period of zero replaces every blanking-start. The normal operating value is 0x1FF.

A second path gives a one-shot forced substitution for leaving a power-save state quickly. A single-cycle arm pulse starts an internal count of blanking-starts. When that count reaches a separately loaded value, typically 5, the next blanking-start is replaced exactly once, and the arm then clears itself. Every substitution, periodic or forced, restarts the periodic count. The output stage is one register deep. The scrambler-reset strobe is high in the same cycle that the substituted symbol leaves the block.

Top module: `bs_sr_swap`

## Requirements
- R1: While reset is held and after it is released, outSym is 0, srStrobe and outBs are 0, the periodic count is zero and the forced path is disarmed.
- R2: An input cycle with inBs low is emitted one cycle later with outSym equal to inSym and with srStrobe and outBs low, whatever the counts and the arm state are.
- R3: With periodCount equal to N, N blanking-starts leave the block unchanged between two consecutive substitutions. With N equal to 0, every blanking-start is replaced.
- R4: A replaced blanking-start appears one cycle later with every lane equal to SR_SYM, srStrobe high and outBs low. A blanking-start that is not replaced appears one cycle later with its input lanes, outBs high and srStrobe low.
- R5: After an arm pulse, loadCount blanking-starts pass the forced path, and the next blanking-start is replaced. With loadCount equal to 0, the first blanking-start after the arm cycle is replaced.
- R6: A forced substitution happens once per arm pulse. The arm clears itself, so later blanking-starts follow the periodic rule only.
- R7: Every substitution, forced ones included, restarts the periodic count from zero.
- R8: If periodCount is lowered to or below the number of blanking-starts already passed, the next blanking-start is replaced.
- R9: An arm pulse while the block is already armed restarts the forced count. A blanking-start in the cycle of an arm pulse is not counted toward the forced substitution and is not replaced by it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inSym | input | LANES*SYM_W | Input symbols, lane 0 in the low bits |
| inBs | input | 1 | Current input cycle is a blanking-start |
| periodCount | input | CNT_W | Blanking-starts passed between periodic substitutions |
| loadCount | input | LOAD_W | Blanking-starts passed after arming before the forced substitution |
| armPulse | input | 1 | One-cycle pulse that arms the forced substitution |
| outSym | output | LANES*SYM_W | Output symbols, one cycle after input |
| outBs | output | 1 | Output cycle is a blanking-start that passed unchanged |
| srStrobe | output | 1 | Output cycle carries a substituted scrambler-reset |

## Verification
The bench builds the block with two lanes of 10-bit symbols and the default 9-bit period and 4-bit load widths. Two lanes are enough to show that a substitution reaches every lane. The 9-bit period makes the full 0x1FF operating value cheap to exercise, so 511 pass-through blanking-starts followed by one replacement fit in a short run. Small periods and loads expose the forced-versus-periodic interaction, re-arming, arming in a blanking-start cycle and lowering the period at run time.

// File: rtl/bs_sr_swap_pkg.sv
package bs_sr_swap_pkg;

  // Strobes passed from the control counters to the output datapath.
  typedef struct packed {
    logic bsSeen;   // current input cycle carries a blanking-start
    logic subst;    // that blanking-start must become a scrambler-reset
  } swapStrobe_t;

endpackage

// File: rtl/bs_sr_swap_ctrl.sv
module bs_sr_swap_ctrl
  import bs_sr_swap_pkg::*;
#(
  parameter int CNT_W  = 9,
  parameter int LOAD_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inBs,
  input  logic              armPulse,
  input  logic [CNT_W-1:0]  periodCount,
  input  logic [LOAD_W-1:0] loadCount,
  output swapStrobe_t       strb
);

  localparam logic [CNT_W-1:0]  PASS_ONE  = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [LOAD_W-1:0] FORCE_ONE = {{(LOAD_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0]  passCnt;
  logic [LOAD_W-1:0] forceCnt;
  logic              armed;

  logic periodHit;
  logic forceHit;
  logic substNow;

  // A greater-or-equal compare covers a period lowered at run time.
  // The counters never wrap: reaching the limit always causes a hit.
  always_comb begin
    periodHit = (passCnt >= periodCount);
    forceHit  = armed && !armPulse && (forceCnt >= loadCount);
    substNow  = inBs && (periodHit || forceHit);
  end

  // Periodic count of passed blanking-starts
  always_ff @(posedge clk) begin
    if (!rstN) begin
      passCnt <= '0;
    end else if (inBs) begin
      if (substNow) passCnt <= '0;
      else          passCnt <= passCnt + PASS_ONE;
    end
  end

  // One-shot forced path; arming has priority and restarts the count
  always_ff @(posedge clk) begin
    if (!rstN) begin
      armed    <= 1'b0;
      forceCnt <= '0;
    end else if (armPulse) begin
      armed    <= 1'b1;
      forceCnt <= '0;
    end else if (armed && inBs) begin
      if (forceHit) begin
        armed    <= 1'b0;
        forceCnt <= '0;
      end else begin
        forceCnt <= forceCnt + FORCE_ONE;
      end
    end
  end

  always_comb begin
    strb.bsSeen = inBs;
    strb.subst  = substNow;
  end

endmodule

// File: rtl/bs_sr_swap_dp.sv
module bs_sr_swap_dp
  import bs_sr_swap_pkg::*;
#(
  parameter int               LANES  = 4,
  parameter int               SYM_W  = 10,
  parameter logic [SYM_W-1:0] SR_SYM = 10'h1C3
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [LANES*SYM_W-1:0] inSym,
  input  swapStrobe_t            strb,
  output logic [LANES*SYM_W-1:0] outSym,
  output logic                   outBs,
  output logic                   srStrobe
);

  localparam int BUS_W = LANES * SYM_W;

  logic [BUS_W-1:0] symNext;

  // Per-lane replacement mux
  for (genvar lane = 0; lane < LANES; lane++) begin : g_lane
    always_comb begin
      if (strb.subst) symNext[lane*SYM_W +: SYM_W] = SR_SYM;
      else            symNext[lane*SYM_W +: SYM_W] = inSym[lane*SYM_W +: SYM_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outSym   <= '0;
      outBs    <= 1'b0;
      srStrobe <= 1'b0;
    end else begin
      outSym   <= symNext;
      outBs    <= strb.bsSeen && !strb.subst;
      srStrobe <= strb.subst;
    end
  end

endmodule

// File: rtl/bs_sr_swap.sv
module bs_sr_swap
  import bs_sr_swap_pkg::*;
#(
  parameter int               LANES  = 4,
  parameter int               SYM_W  = 10,
  parameter int               CNT_W  = 9,
  parameter int               LOAD_W = 4,
  parameter logic [SYM_W-1:0] SR_SYM = 10'h1C3
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [LANES*SYM_W-1:0] inSym,
  input  logic                   inBs,
  input  logic [CNT_W-1:0]       periodCount,
  input  logic [LOAD_W-1:0]      loadCount,
  input  logic                   armPulse,
  output logic [LANES*SYM_W-1:0] outSym,
  output logic                   outBs,
  output logic                   srStrobe
);

  swapStrobe_t strb;

  bs_sr_swap_ctrl #(
    .CNT_W (CNT_W),
    .LOAD_W(LOAD_W)
  ) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .inBs       (inBs),
    .armPulse   (armPulse),
    .periodCount(periodCount),
    .loadCount  (loadCount),
    .strb       (strb)
  );

  bs_sr_swap_dp #(
    .LANES (LANES),
    .SYM_W (SYM_W),
    .SR_SYM(SR_SYM)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .inSym   (inSym),
    .strb    (strb),
    .outSym  (outSym),
    .outBs   (outBs),
    .srStrobe(srStrobe)
  );

endmodule

// File: rtl/bs_sr_swap_chk.sv
module bs_sr_swap_chk #(
  parameter int               LANES  = 4,
  parameter int               SYM_W  = 10,
  parameter int               CNT_W  = 9,
  parameter int               LOAD_W = 4,
  parameter logic [SYM_W-1:0] SR_SYM = 10'h1C3
) (
  input logic                   clk,
  input logic                   rstN,
  input logic [LANES*SYM_W-1:0] inSym,
  input logic                   inBs,
  input logic [CNT_W-1:0]       periodCount,
  input logic [LOAD_W-1:0]      loadCount,
  input logic                   armPulse,
  input logic [LANES*SYM_W-1:0] outSym,
  input logic                   outBs,
  input logic                   srStrobe
);

  // R4
  lanes_sr_chk: assert property (@(posedge clk) disable iff (!rstN)
    srStrobe |-> (outSym == {LANES{SR_SYM}}));

  // R4
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(srStrobe && outBs));

  // R4
  bs_marked_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(inBs) |-> (srStrobe || outBs));

  // R2
  no_bs_no_sub_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(inBs) |-> (!srStrobe && !outBs));

  // R2
  passthrough_chk: assert property (@(posedge clk) disable iff (!rstN)
    !srStrobe |-> (outSym == $past(inSym)));

  // R3
  every_bs_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(inBs) && ($past(periodCount) == '0)) |-> srStrobe);

endmodule

bind bs_sr_swap bs_sr_swap_chk #(
  .LANES (LANES),
  .SYM_W (SYM_W),
  .CNT_W (CNT_W),
  .LOAD_W(LOAD_W),
  .SR_SYM(SR_SYM)
) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .inSym      (inSym),
  .inBs       (inBs),
  .periodCount(periodCount),
  .loadCount  (loadCount),
  .armPulse   (armPulse),
  .outSym     (outSym),
  .outBs      (outBs),
  .srStrobe   (srStrobe)
);

// File: tb/bs_sr_swap_tb_top.sv
`timescale 1ns/1ps
module bs_sr_swap_tb_top;

  localparam int               LANES  = 2;
  localparam int               SYM_W  = 10;
  localparam int               CNT_W  = 9;
  localparam int               LOAD_W = 4;
  localparam logic [SYM_W-1:0] SR_SYM = 10'h1C3;
  localparam int               BUS_W  = LANES * SYM_W;

  logic               clk = 1'b0;
  logic               rstN;
  logic [BUS_W-1:0]   inSym;
  logic               inBs;
  logic [CNT_W-1:0]   periodCount;
  logic [LOAD_W-1:0]  loadCount;
  logic               armPulse;
  logic [BUS_W-1:0]   outSym;
  logic               outBs;
  logic               srStrobe;

  int  testCnt = 0;
  int  failCnt = 0;
  int  seed    = 0;
  bit  done    = 1'b0;

  always #2 clk = ~clk;

  bs_sr_swap #(
    .LANES(LANES), .SYM_W(SYM_W), .CNT_W(CNT_W), .LOAD_W(LOAD_W), .SR_SYM(SR_SYM)
  ) dut_i (
    .clk(clk), .rstN(rstN), .inSym(inSym), .inBs(inBs),
    .periodCount(periodCount), .loadCount(loadCount), .armPulse(armPulse),
    .outSym(outSym), .outBs(outBs), .srStrobe(srStrobe)
  );

  // Vector fields: {bs, arm, expected substitution}; run with period 2, load 1
  typedef struct packed {
    logic bs;
    logic arm;
    logic expSr;
  } vec_t;

  localparam int NVEC = 11;
  localparam vec_t VECS [NVEC] = '{
    3'b100, 3'b000, 3'b100, 3'b101, 3'b010, 3'b100,
    3'b101, 3'b100, 3'b100, 3'b101, 3'b100
  };

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; inBs = 1'b0; armPulse = 1'b0; inSym = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  // Drive one cycle, then check the registered output after the next edge.
  task automatic step(input logic bs, input logic arm, input logic expSr, input string req);
    logic [BUS_W-1:0] expSym;
    @(negedge clk);
    inBs = bs; armPulse = arm; seed++;
    for (int l = 0; l < LANES; l++)
      inSym[l*SYM_W +: SYM_W] = SYM_W'(seed * 37 + l * 5 + 3);
    expSym = expSr ? {LANES{SR_SYM}} : inSym;
    @(posedge clk); #1;
    check(srStrobe == expSr, {req, " strobe"}, 32'(srStrobe), 32'(expSr));
    check(outSym == expSym, {req, " symbols"}, 32'(outSym), 32'(expSym));
    check(outBs == (bs && !expSr), {req, " bs flag"}, 32'(outBs), 32'(bs && !expSr));
    @(negedge clk);
    armPulse = 1'b0; inBs = 1'b0;
  endtask

  initial begin
    rstN = 1'b0; inBs = 1'b0; armPulse = 1'b0; inSym = '0;
    periodCount = 9'd2; loadCount = 4'd1;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check(outSym == '0, "R1 reset symbols", 32'(outSym), 0);
    check(!srStrobe && !outBs, "R1 reset flags", {30'd0, srStrobe, outBs}, 0);
    @(negedge clk);
    rstN = 1'b1;
    step(1'b0, 1'b0, 1'b0, "R1 first cycle after reset");

    // Vector walk: R3 R4 R5 R6 R7 with period 2, load 1
    doReset();
    for (int i = 0; i < NVEC; i++)
      step(VECS[i].bs, VECS[i].arm, VECS[i].expSr, $sformatf("R3/R5 vector %0d", i));

    // R3: period 0 replaces every blanking-start; R2: others untouched
    doReset();
    periodCount = '0;
    step(1'b1, 1'b0, 1'b1, "R3 period0 a");
    step(1'b0, 1'b0, 1'b0, "R2 period0 gap");
    step(1'b1, 1'b0, 1'b1, "R3 period0 b");
    step(1'b1, 1'b0, 1'b1, "R3 period0 c");

    // R3: operating value 0x1FF
    doReset();
    periodCount = 9'h1FF;
    for (int i = 0; i < 511; i++) step(1'b1, 1'b0, 1'b0, "R3 1FF pass");
    step(1'b1, 1'b0, 1'b1, "R3 1FF replace");
    step(1'b1, 1'b0, 1'b0, "R3 1FF after");

    // R5 R6: forced with load 5, once only
    doReset();
    periodCount = 9'h1FF; loadCount = 4'd5;
    step(1'b0, 1'b1, 1'b0, "R5 arm");
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 1'b0, "R5 pass");
    step(1'b1, 1'b0, 1'b1, "R5 forced");
    for (int i = 0; i < 8; i++) step(1'b1, 1'b0, 1'b0, "R6 once");

    // R7: forced substitution restarts the periodic count
    doReset();
    periodCount = 9'd3; loadCount = 4'd0;
    step(1'b1, 1'b0, 1'b0, "R7 pre a");
    step(1'b1, 1'b0, 1'b0, "R7 pre b");
    step(1'b0, 1'b1, 1'b0, "R7 arm");
    step(1'b1, 1'b0, 1'b1, "R7 forced");
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b0, "R7 restart pass");
    step(1'b1, 1'b0, 1'b1, "R7 periodic");

    // R8: period lowered below passed count
    doReset();
    periodCount = 9'd10;
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 1'b0, "R8 pass");
    periodCount = 9'd2;
    step(1'b1, 1'b0, 1'b1, "R8 lowered");

    // R9: re-arm restarts the forced count
    doReset();
    periodCount = 9'h1FF; loadCount = 4'd3;
    step(1'b0, 1'b1, 1'b0, "R9 arm");
    step(1'b1, 1'b0, 1'b0, "R9 first pass");
    step(1'b1, 1'b0, 1'b0, "R9 second pass");
    step(1'b0, 1'b1, 1'b0, "R9 rearm");
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b0, "R9 restart pass");
    step(1'b1, 1'b0, 1'b1, "R9 forced");

    // R9: blanking-start in the arm cycle is not counted
    doReset();
    loadCount = 4'd1;
    step(1'b1, 1'b1, 1'b0, "R9 arm with bs");
    step(1'b1, 1'b0, 1'b0, "R9 counted");
    step(1'b1, 1'b0, 1'b1, "R9 forced after");

    // R2: non-blanking symbols untouched while armed with load 0
    doReset();
    loadCount = 4'd0;
    step(1'b0, 1'b1, 1'b0, "R2 arm");
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b0, "R2 armed idle");
    step(1'b1, 1'b0, 1'b1, "R5 load0 first bs");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failCnt++;
      testCnt++;
      $display("FAIL watchdog all requirements actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

endmodule